// File: doc/BRIEF.md
# Burst and Adaptive UVLO Supervisor

This block sits in the digital core of an offline flyback controller. It decides when the power switch may run and which supply undervoltage level applies. It also controls the high-voltage start-up current source. Its inputs are comparator decisions that the analog front end has already made: three feedback-level flags, four supply-level flags and a flag that says the rectified line is high enough to feed the start-up source. All inputs pass through a parameterised synchronizer. Every output is registered.

A mode machine with the states OFF, STARTUP, RUN, BURST_IDLE and BURST_SWITCH drives the outputs.
- In STARTUP the high-voltage source charges the supply capacitor. The source works at reduced current while the supply is still below the foldback level.
- When the supply reaches the turn-on level, switching begins.
- Under light load the feedback falls below the burst-entry level. Switching then stops, the reduced peak-current clamp is selected and the UVLO threshold drops to its lower value.
- Switching resumes in burst when the feedback climbs back to the burst level.
- Normal operation, and with it the normal UVLO threshold, returns only when the feedback passes the higher exit level.
- The UVLO flag that applies is chosen through a registered mux. If the supply falls below that threshold in any switching state, the machine goes to OFF.

Top module: `burst_uvlo_supervisor`

## Requirements
- R1: After reset every output (sw_en, burst_act, uvlo_low_sel, hv_src_en, hv_fold_sel) is 0.
- R2: hv_src_en is 1 only when hv_above_start is 1, the mode is OFF or STARTUP, and vdd_above_on is 0. It is 0 in RUN and in both burst states, even after the supply drops back below the turn-on level.
- R3: hv_fold_sel is 1 exactly when hv_src_en is 1 and vdd_above_fold is 0, which selects the reduced charge current.
- R4: In STARTUP, vdd_above_on = 1 moves the mode to RUN: sw_en = 1 and burst_act = 0. Feedback flags have no effect in OFF or STARTUP.
- R5: In RUN or BURST_SWITCH, fb_below_entry = 1 moves the mode to BURST_IDLE: sw_en = 0, burst_act = 1 and uvlo_low_sel = 1.
- R6: In BURST_IDLE, fb_above_resume = 1 moves the mode to BURST_SWITCH: sw_en = 1 and burst_act = 1. uvlo_low_sel stays 1.
- R7: Only BURST_SWITCH with fb_above_exit = 1 returns the mode to RUN, and this clears uvlo_low_sel. BURST_IDLE never goes straight to RUN.
- R8: In RUN, BURST_IDLE and BURST_SWITCH, the registered UVLO flag is checked: vdd_above_uvlo_burst when uvlo_low_sel is 1, otherwise vdd_above_uvlo_norm. If that flag is 0, the mode goes to OFF, which clears sw_en, burst_act and uvlo_low_sel. During burst the normal flag is ignored.
- R9: In STARTUP, hv_above_start = 0 returns the mode to OFF and turns the source off. OFF moves to STARTUP whenever hv_above_start = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_below_entry | input | 1 | Feedback below burst level minus hysteresis |
| fb_above_resume | input | 1 | Feedback at or above burst level |
| fb_above_exit | input | 1 | Feedback above burst-exit level |
| vdd_above_fold | input | 1 | Supply above foldback level |
| vdd_above_uvlo_norm | input | 1 | Supply above normal UVLO level |
| vdd_above_uvlo_burst | input | 1 | Supply above lowered UVLO level |
| vdd_above_on | input | 1 | Supply above turn-on level |
| hv_above_start | input | 1 | Line high enough for the start-up source |
| sw_en | output | 1 | Switching enable |
| burst_act | output | 1 | Burst active, selects low peak-current clamp |
| uvlo_low_sel | output | 1 | Lowered UVLO threshold selected |
| hv_src_en | output | 1 | Start-up current source enable |
| hv_fold_sel | output | 1 | Start-up source reduced-current select |

## Verification
The bench checks the hysteresis between the three feedback levels.
- A design that restored the normal UVLO threshold on burst resume, rather than on exit, would show uvlo_low_sel = 0 in BURST_SWITCH.
- A design that went from BURST_IDLE straight to RUN would never enter BURST_SWITCH.

The bench drops the supply into the band between the two UVLO levels while bursting. A design that checked the wrong flag would shut down there.

The bench also lowers the supply below turn-on while running. A design that re-enabled the start-up source there would assert hv_src_en in RUN.

It also removes the line during start-up, and feeds burst-entry feedback before turn-on.

// File: rtl/bsup_pkg.sv
package bsup_pkg;
  localparam int FLAG_N    = 8;
  localparam int IX_FB_LO  = 0;
  localparam int IX_FB_RES = 1;
  localparam int IX_FB_EX  = 2;
  localparam int IX_V_FOLD = 3;
  localparam int IX_V_UVN  = 4;
  localparam int IX_V_UVB  = 5;
  localparam int IX_V_ON   = 6;
  localparam int IX_HV     = 7;

  typedef enum logic [2:0] {
    M_OFF      = 3'd0,
    M_STARTUP  = 3'd1,
    M_RUN      = 3'd2,
    M_BIDLE    = 3'd3,
    M_BSWITCH  = 3'd4
  } mode_t;
endpackage

// File: rtl/bsup_sync.sv
module bsup_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/bsup_uvlo_sel.sv
module bsup_uvlo_sel (
  input  logic clk,
  input  logic rst,
  input  logic low_sel,
  input  logic above_norm,
  input  logic above_burst,
  output logic uvlo_ok
);
  always_ff @(posedge clk) begin
    if (rst) uvlo_ok <= 1'b0;
    else     uvlo_ok <= low_sel ? above_burst : above_norm;
  end
endmodule

// File: rtl/bsup_mode_fsm.sv
module bsup_mode_fsm
  import bsup_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  fb_lo,
  input  logic  fb_res,
  input  logic  fb_ex,
  input  logic  v_on,
  input  logic  hv_ok,
  input  logic  uvlo_ok,
  output mode_t mode,
  output logic  uvlo_low
);
  mode_t nx;
  logic  low_nx;

  always_comb begin
    nx = mode;
    unique case (mode)
      M_OFF:     if (hv_ok) nx = M_STARTUP;
      M_STARTUP: begin
        if (!hv_ok)     nx = M_OFF;
        else if (v_on)  nx = M_RUN;
      end
      M_RUN: begin
        if (!uvlo_ok)   nx = M_OFF;
        else if (fb_lo) nx = M_BIDLE;
      end
      M_BIDLE: begin
        if (!uvlo_ok)    nx = M_OFF;
        else if (fb_res) nx = M_BSWITCH;
      end
      M_BSWITCH: begin
        if (!uvlo_ok)   nx = M_OFF;
        else if (fb_lo) nx = M_BIDLE;
        else if (fb_ex) nx = M_RUN;
      end
      default: nx = M_OFF;
    endcase
  end

  always_comb begin
    low_nx = uvlo_low;
    if (nx == M_OFF)        low_nx = 1'b0;
    else if (nx == M_BIDLE) low_nx = 1'b1;
    else if (nx == M_RUN)   low_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= M_OFF;
      uvlo_low <= 1'b0;
    end else begin
      mode     <= nx;
      uvlo_low <= low_nx;
    end
  end
endmodule

// File: rtl/bsup_out_reg.sv
module bsup_out_reg
  import bsup_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t mode,
  input  logic  uvlo_low,
  input  logic  hv_ok,
  input  logic  v_on,
  input  logic  v_fold,
  output logic  sw_en,
  output logic  burst_act,
  output logic  uvlo_low_sel,
  output logic  hv_src_en,
  output logic  hv_fold_sel
);
  logic charging;
  assign charging = hv_ok && !v_on && (mode == M_OFF || mode == M_STARTUP);

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_en        <= 1'b0;
      burst_act    <= 1'b0;
      uvlo_low_sel <= 1'b0;
      hv_src_en    <= 1'b0;
      hv_fold_sel  <= 1'b0;
    end else begin
      sw_en        <= (mode == M_RUN) || (mode == M_BSWITCH);
      burst_act    <= (mode == M_BIDLE) || (mode == M_BSWITCH);
      uvlo_low_sel <= uvlo_low;
      hv_src_en    <= charging;
      hv_fold_sel  <= charging && !v_fold;
    end
  end
endmodule

// File: rtl/burst_uvlo_supervisor.sv
module burst_uvlo_supervisor
  import bsup_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fb_below_entry,
  input  logic fb_above_resume,
  input  logic fb_above_exit,
  input  logic vdd_above_fold,
  input  logic vdd_above_uvlo_norm,
  input  logic vdd_above_uvlo_burst,
  input  logic vdd_above_on,
  input  logic hv_above_start,
  output logic sw_en,
  output logic burst_act,
  output logic uvlo_low_sel,
  output logic hv_src_en,
  output logic hv_fold_sel
);
  logic [FLAG_N-1:0] raw, syn;
  mode_t mode;
  logic  uvlo_low, uvlo_ok;

  always_comb begin
    raw            = '0;
    raw[IX_FB_LO]  = fb_below_entry;
    raw[IX_FB_RES] = fb_above_resume;
    raw[IX_FB_EX]  = fb_above_exit;
    raw[IX_V_FOLD] = vdd_above_fold;
    raw[IX_V_UVN]  = vdd_above_uvlo_norm;
    raw[IX_V_UVB]  = vdd_above_uvlo_burst;
    raw[IX_V_ON]   = vdd_above_on;
    raw[IX_HV]     = hv_above_start;
  end

  bsup_sync #(.WIDTH(FLAG_N), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  bsup_uvlo_sel i_usel (
    .clk(clk), .rst(rst), .low_sel(uvlo_low),
    .above_norm(syn[IX_V_UVN]), .above_burst(syn[IX_V_UVB]),
    .uvlo_ok(uvlo_ok)
  );

  bsup_mode_fsm i_fsm (
    .clk(clk), .rst(rst),
    .fb_lo(syn[IX_FB_LO]), .fb_res(syn[IX_FB_RES]), .fb_ex(syn[IX_FB_EX]),
    .v_on(syn[IX_V_ON]), .hv_ok(syn[IX_HV]), .uvlo_ok(uvlo_ok),
    .mode(mode), .uvlo_low(uvlo_low)
  );

  bsup_out_reg i_out (
    .clk(clk), .rst(rst), .mode(mode), .uvlo_low(uvlo_low),
    .hv_ok(syn[IX_HV]), .v_on(syn[IX_V_ON]), .v_fold(syn[IX_V_FOLD]),
    .sw_en(sw_en), .burst_act(burst_act), .uvlo_low_sel(uvlo_low_sel),
    .hv_src_en(hv_src_en), .hv_fold_sel(hv_fold_sel)
  );
endmodule

// File: rtl/bsup_checker.sv
module bsup_checker (
  input logic clk,
  input logic rst,
  input logic sw_en,
  input logic burst_act,
  input logic uvlo_low_sel,
  input logic hv_src_en,
  input logic hv_fold_sel
);
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(sw_en || burst_act || uvlo_low_sel || hv_src_en || hv_fold_sel));

  p_src_off_while_switching_r2: assert property (@(posedge clk) disable iff (rst)
    sw_en |-> !hv_src_en);

  p_fold_only_with_src_r3: assert property (@(posedge clk) disable iff (rst)
    hv_fold_sel |-> hv_src_en);

  p_idle_has_low_uvlo_r5: assert property (@(posedge clk) disable iff (rst)
    (burst_act && !sw_en) |-> uvlo_low_sel);

  p_no_idle_to_run_r7: assert property (@(posedge clk) disable iff (rst)
    (burst_act && !sw_en) |=> !(sw_en && !burst_act));
endmodule

bind burst_uvlo_supervisor bsup_checker i_bsup_checker (
  .clk(clk), .rst(rst), .sw_en(sw_en), .burst_act(burst_act),
  .uvlo_low_sel(uvlo_low_sel), .hv_src_en(hv_src_en), .hv_fold_sel(hv_fold_sel)
);

// File: tb/test_burst_uvlo_supervisor.sv
module test_burst_uvlo_supervisor;
  localparam time CLK_PERIOD = 10ns;
  localparam int  SETTLE     = 8;
  localparam int  WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fb_lo = 0, fb_res = 0, fb_ex = 0;
  logic v_fold = 0, v_uvn = 0, v_uvb = 0, v_on = 0, hv = 0;
  logic sw_en, burst_act, uvlo_low_sel, hv_src_en, hv_fold_sel;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  logic [4:0] exp_q [$];
  string      tag_q [$];
  event       ev_chk;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_uvlo_supervisor i_burst_uvlo_supervisor (
    .clk(clk), .rst(rst),
    .fb_below_entry(fb_lo), .fb_above_resume(fb_res), .fb_above_exit(fb_ex),
    .vdd_above_fold(v_fold), .vdd_above_uvlo_norm(v_uvn),
    .vdd_above_uvlo_burst(v_uvb), .vdd_above_on(v_on), .hv_above_start(hv),
    .sw_en(sw_en), .burst_act(burst_act), .uvlo_low_sel(uvlo_low_sel),
    .hv_src_en(hv_src_en), .hv_fold_sel(hv_fold_sel)
  );

  // monitor: expected vector is {sw_en, burst_act, uvlo_low_sel, hv_src_en, hv_fold_sel}
  initial begin
    forever begin
      @(ev_chk);
      while (exp_q.size() > 0) begin
        logic [4:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {sw_en, burst_act, uvlo_low_sel, hv_src_en, hv_fold_sel};
        vectors++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: got %b expected %b", t, a, e);
        end
      end
    end
  end

  task automatic expect_now(input logic [4:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    -> ev_chk;
    #1;
  endtask

  task automatic drive(input logic [2:0] fb, input logic [3:0] vdd, input logic h,
                       input logic [4:0] e, input string t);
    @(negedge clk);
    {fb_lo, fb_res, fb_ex} = fb;
    {v_fold, v_uvn, v_uvb, v_on} = vdd;
    hv = h;
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
    expect_now(e, t);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_now(5'b00000, "R1 during reset");
    rst = 1'b0;
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
    expect_now(5'b00000, "R1 after reset, no line");
    // vdd vector {fold, uvlo_norm, uvlo_burst, on}; fb vector {entry, resume, exit}
    drive(3'b000, 4'b0000, 1, 5'b00011, "R2 R3 startup below foldback");
    drive(3'b000, 4'b1000, 1, 5'b00010, "R3 full charge current");
    drive(3'b100, 4'b1000, 1, 5'b00010, "R4 feedback ignored in startup");
    drive(3'b000, 4'b1000, 0, 5'b00000, "R9 line lost in startup");
    drive(3'b000, 4'b1000, 1, 5'b00010, "R9 line back restarts charging");
    drive(3'b000, 4'b1111, 1, 5'b10000, "R4 R2 turn-on reached");
    drive(3'b000, 4'b1110, 1, 5'b10000, "R2 source stays off in run");
    drive(3'b011, 4'b1110, 1, 5'b10000, "R7 high feedback keeps run");
    drive(3'b100, 4'b1110, 1, 5'b01100, "R5 burst entry from run");
    drive(3'b000, 4'b1110, 1, 5'b01100, "R6 hysteresis holds idle");
    drive(3'b010, 4'b1110, 1, 5'b11100, "R6 resume keeps low uvlo");
    drive(3'b010, 4'b1010, 1, 5'b11100, "R8 normal uvlo ignored in burst");
    drive(3'b100, 4'b1110, 1, 5'b01100, "R5 burst entry from burst switch");
    drive(3'b010, 4'b1110, 1, 5'b11100, "R6 second resume");
    drive(3'b011, 4'b1110, 1, 5'b10000, "R7 exit level restores normal uvlo");
    drive(3'b010, 4'b1010, 1, 5'b00010, "R8 normal uvlo trip in run");
    drive(3'b000, 4'b1111, 1, 5'b10000, "R4 second turn-on");
    drive(3'b100, 4'b1110, 1, 5'b01100, "R5 burst entry again");
    drive(3'b100, 4'b1000, 1, 5'b00010, "R8 burst uvlo trip in idle");
    drive(3'b000, 4'b1111, 1, 5'b10000, "R4 third turn-on");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    expect_now(5'b00000, "R1 reset while running");
    rst = 1'b0;
    repeat (2) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule